// File: doc/BRIEF.md
# Branch and Skip Program Counter Unit

This unit resolves the control-flow instructions of a single-issue 8-bit core whose program memory holds 16-bit words. For each instruction it receives, it works out the address of the next instruction, whether control left the straight-line path, and how many execution cycles the instruction costs. The instruction must already be decoded, so the unit sees an operation code. It also receives the current program counter, the immediate offset, the low bits of the Z pointer, the address popped from the stack, the status register, a bit selector, the skip condition and a flag saying whether the instruction after the current one is two words long.

The unit handles these instruction families:
- relative and indirect jumps and calls,
- subroutine and interrupt returns,
- conditional branches on any status bit, either set or clear,
- skips, which step over the following instruction whether that instruction is one word or two.

All program-counter arithmetic wraps around the 1K-word program space. Each result is registered and appears one clock after the instruction is presented. The result then holds until the next valid instruction arrives.

Top module: `bpu_top`

## Requirements
- R1: While `rst` is high, and after it is released with no instruction presented, `out_valid`, `pc_next`, `taken`, `cycles` and `set_ie` are all zero.
- R2: `out_valid` equals the previous cycle's `in_valid`, and the results update one clock after an instruction is presented. When `in_valid` is low the results keep their last values.
- R3: Op 0 (relative jump) and op 2 (relative call) give `pc_next` = `pc_in` + k + 1, with k the signed 12-bit `k_in`. `taken` is 1. `cycles` is 2 for the jump and 3 for the call.
- R4: Op 1 (indirect jump) and op 3 (indirect call) give `pc_next` = `z_in`, with `taken` 1. `cycles` is 2 for the jump and 3 for the call.
- R5: Op 4 (return) and op 5 (interrupt return) give `pc_next` = `ret_in`, `taken` 1 and `cycles` 4. `set_ie` is 1 for op 5 only.
- R6: Op 6 branches when the selected status bit is 1, and op 7 branches when it is 0. `bit_sel` picks the bit in the order 0=C, 1=Z, 2=N, 3=V, 4=S, 5=H, 6=T, 7=I. When taken, `pc_next` = `pc_in` + k + 1 with k the signed 7-bit `k_in[6:0]`, and `cycles` is 2. When not taken, `pc_next` = `pc_in` + 1, `taken` is 0 and `cycles` is 1.
- R7: For a branch with `bit_sel` = 4, the condition is N xor V (`sreg_in[2]` ^ `sreg_in[3]`). The stored `sreg_in[4]` has no effect.
- R8: Op 8 (skip) behaves as follows:
  - With `skip_hit` 0: `pc_next` = `pc_in` + 1, `taken` 0, `cycles` 1.
  - With `skip_hit` 1 and `next_long` 0: `pc_in` + 2 and 2 cycles.
  - With `skip_hit` 1 and `next_long` 1: `pc_in` + 3 and 3 cycles.
  - `taken` is 1 in both hit cases.
- R9: Op codes 9 to 15 give `pc_next` = `pc_in` + 1, `taken` 0, `cycles` 1 and `set_ie` 0.
- R10: Every computed address wraps modulo 1024, for both forward and backward offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_in | input | 4 | Decoded control-flow operation code |
| pc_in | input | 10 | Address of the current instruction |
| k_in | input | 12 | Signed offset (branches use bits 6:0) |
| z_in | input | 10 | Word address held in the Z pointer |
| ret_in | input | 10 | Return address popped from the stack |
| sreg_in | input | 8 | Status flags C,Z,N,V,S,H,T,I at bits 0..7 |
| bit_sel | input | 3 | Status bit tested by a branch |
| skip_hit | input | 1 | Skip condition holds |
| next_long | input | 1 | Following instruction is two words |
| out_valid | output | 1 | Result registered this cycle |
| pc_next | output | 10 | Next program counter |
| taken | output | 1 | Control left sequential flow |
| cycles | output | 3 | Execution cycles of the instruction |
| set_ie | output | 1 | Interrupt return: set the I flag |

## Verification
The bench checks wraparound at both ends of the program space. A jump from the top address with a zero offset must land on 0, and a branch with the most negative 7-bit offset near the bottom must wrap high. A design that zero-extends offsets or carries into an eleventh bit would land far off.

Each status bit is tested with both branch polarities. The signed bit is given a stored value that disagrees with N xor V, which exposes a design that reads the stored bit.

All three skip outcomes are covered. A unit that ignores the length of the next instruction would land one word short and report 2 cycles instead of 3.

Idle cycles between instructions confirm that the results hold and that `out_valid` drops.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [3:0] {
        OP_RJMP  = 4'd0,
        OP_IJMP  = 4'd1,
        OP_RCALL = 4'd2,
        OP_ICALL = 4'd3,
        OP_RET   = 4'd4,
        OP_RETI  = 4'd5,
        OP_BRSET = 4'd6,
        OP_BRCLR = 4'd7,
        OP_SKIP  = 4'd8
    } cf_op_e;

    // status bit positions
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;

    // cycle costs
    localparam int CYC_SEQ   = 1;
    localparam int CYC_JUMP  = 2;
    localparam int CYC_CALL  = 3;
    localparam int CYC_RET   = 4;
    localparam int CYC_BR_TK = 2;

    function automatic logic is_branch(cf_op_e op);
        return (op == OP_BRSET) || (op == OP_BRCLR);
    endfunction

    function automatic logic is_relative(cf_op_e op);
        return (op == OP_RJMP) || (op == OP_RCALL);
    endfunction

endpackage

// File: rtl/bpu_cond.sv
module bpu_cond
    import bpu_pkg::*;
(
    input  logic [7:0] sreg,
    input  logic [2:0] sel,
    input  cf_op_e     op,
    output logic       hit
);
    logic bit_val;

    always_comb begin
        bit_val = sreg[sel];
        if (sel == 3'(FLG_S))
            bit_val = sreg[FLG_N] ^ sreg[FLG_V];
        hit = (op == OP_BRSET) ? bit_val : ~bit_val;
    end
endmodule

// File: rtl/bpu_target.sv
module bpu_target
    import bpu_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int JK_W = 12,
    parameter int BK_W = 7
) (
    input  cf_op_e            op,
    input  logic [PC_W-1:0]   pc,
    input  logic [JK_W-1:0]   k,
    input  logic [PC_W-1:0]   z,
    input  logic [PC_W-1:0]   ret,
    input  logic              br_hit,
    input  logic              skip_hit,
    input  logic              next_long,
    output logic [PC_W-1:0]   target,
    output logic              taken
);
    localparam logic [PC_W-1:0] ONE   = PC_W'(1);
    localparam logic [PC_W-1:0] TWO   = PC_W'(2);
    localparam logic [PC_W-1:0] THREE = PC_W'(3);

    logic [PC_W-1:0] jump_off;
    logic [PC_W-1:0] br_off;
    logic [PC_W-1:0] seq_pc;

    // signed offsets resized to the address width (wrap modulo 2^PC_W)
    generate
        if (JK_W >= PC_W) begin : g_jk_trunc
            assign jump_off = k[PC_W-1:0];
        end else begin : g_jk_ext
            assign jump_off = {{(PC_W-JK_W){k[JK_W-1]}}, k};
        end
        if (BK_W >= PC_W) begin : g_bk_trunc
            assign br_off = k[PC_W-1:0];
        end else begin : g_bk_ext
            assign br_off = {{(PC_W-BK_W){k[BK_W-1]}}, k[BK_W-1:0]};
        end
    endgenerate

    assign seq_pc = pc + ONE;

    always_comb begin
        target = seq_pc;
        taken  = 1'b0;
        unique case (op)
            OP_RJMP, OP_RCALL: begin
                target = pc + jump_off + ONE;
                taken  = 1'b1;
            end
            OP_IJMP, OP_ICALL: begin
                target = z;
                taken  = 1'b1;
            end
            OP_RET, OP_RETI: begin
                target = ret;
                taken  = 1'b1;
            end
            OP_BRSET, OP_BRCLR: begin
                taken  = br_hit;
                target = br_hit ? (pc + br_off + ONE) : seq_pc;
            end
            OP_SKIP: begin
                taken  = skip_hit;
                if (skip_hit)
                    target = pc + (next_long ? THREE : TWO);
            end
            default: begin
                target = seq_pc;
                taken  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bpu_cycles.sv
module bpu_cycles
    import bpu_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  cf_op_e           op,
    input  logic             taken,
    input  logic             next_long,
    output logic [CYC_W-1:0] cycles
);
    always_comb begin
        unique case (op)
            OP_RJMP, OP_IJMP:   cycles = CYC_W'(CYC_JUMP);
            OP_RCALL, OP_ICALL: cycles = CYC_W'(CYC_CALL);
            OP_RET, OP_RETI:    cycles = CYC_W'(CYC_RET);
            OP_BRSET, OP_BRCLR: cycles = taken ? CYC_W'(CYC_BR_TK) : CYC_W'(CYC_SEQ);
            OP_SKIP:            cycles = !taken   ? CYC_W'(CYC_SEQ)
                                       : next_long ? CYC_W'(3) : CYC_W'(2);
            default:            cycles = CYC_W'(CYC_SEQ);
        endcase
    end
endmodule

// File: rtl/bpu_top.sv
module bpu_top
    import bpu_pkg::*;
#(
    parameter int PC_W  = 10,
    parameter int JK_W  = 12,
    parameter int BK_W  = 7,
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op_in,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [JK_W-1:0]  k_in,
    input  logic [PC_W-1:0]  z_in,
    input  logic [PC_W-1:0]  ret_in,
    input  logic [7:0]       sreg_in,
    input  logic [2:0]       bit_sel,
    input  logic             skip_hit,
    input  logic             next_long,
    output logic             out_valid,
    output logic [PC_W-1:0]  pc_next,
    output logic             taken,
    output logic [CYC_W-1:0] cycles,
    output logic             set_ie
);
    cf_op_e           op;
    logic             br_hit;
    logic [PC_W-1:0]  tgt;
    logic             tk;
    logic [CYC_W-1:0] cyc;

    assign op = cf_op_e'(op_in);

    bpu_cond u_cond (
        .sreg (sreg_in),
        .sel  (bit_sel),
        .op   (op),
        .hit  (br_hit)
    );

    bpu_target #(.PC_W(PC_W), .JK_W(JK_W), .BK_W(BK_W)) u_target (
        .op        (op),
        .pc        (pc_in),
        .k         (k_in),
        .z         (z_in),
        .ret       (ret_in),
        .br_hit    (br_hit),
        .skip_hit  (skip_hit),
        .next_long (next_long),
        .target    (tgt),
        .taken     (tk)
    );

    bpu_cycles #(.CYC_W(CYC_W)) u_cycles (
        .op        (op),
        .taken     (tk),
        .next_long (next_long),
        .cycles    (cyc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pc_next   <= '0;
            taken     <= 1'b0;
            cycles    <= '0;
            set_ie    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pc_next <= tgt;
                taken   <= tk;
                cycles  <= cyc;
                set_ie  <= (op == OP_RETI);
            end
        end
    end
endmodule

// File: rtl/bpu_chk.sv
module bpu_chk
    import bpu_pkg::*;
#(
    parameter int PC_W  = 10,
    parameter int CYC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       op_in,
    input logic [PC_W-1:0]  pc_in,
    input logic [PC_W-1:0]  z_in,
    input logic [PC_W-1:0]  ret_in,
    input logic             skip_hit,
    input logic             out_valid,
    input logic [PC_W-1:0]  pc_next,
    input logic             taken,
    input logic [CYC_W-1:0] cycles,
    input logic             set_ie
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pc_next) && $stable(cycles) && $stable(taken)));

    p_indirect_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_in == OP_IJMP) |=> (pc_next == $past(z_in) && cycles == CYC_W'(2) && taken));

    p_return_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_in == OP_RET || op_in == OP_RETI))
            |=> (pc_next == $past(ret_in) && cycles == CYC_W'(4) && taken));

    p_setie_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && set_ie) |-> (cycles == CYC_W'(4) && taken));

    p_branch_cyc_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_in == OP_BRSET || op_in == OP_BRCLR))
            |=> ((taken && cycles == CYC_W'(2)) || (!taken && cycles == CYC_W'(1))));

    p_skip_miss_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_in == OP_SKIP && !skip_hit)
            |=> (pc_next == $past(pc_in) + PC_W'(1) && cycles == CYC_W'(1) && !taken));

    p_unused_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_in > 4'd8) |=> (!taken && cycles == CYC_W'(1) && !set_ie));
endmodule

bind bpu_top bpu_chk #(.PC_W(PC_W), .CYC_W(CYC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_in     (op_in),
    .pc_in     (pc_in),
    .z_in      (z_in),
    .ret_in    (ret_in),
    .skip_hit  (skip_hit),
    .out_valid (out_valid),
    .pc_next   (pc_next),
    .taken     (taken),
    .cycles    (cycles),
    .set_ie    (set_ie)
);

// File: tb/tb_bpu_top.sv
module tb_bpu_top;
    localparam int CLK_P = 10;

    typedef struct {
        logic [9:0] pc;
        logic       tk;
        logic [2:0] cy;
        logic       si;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op_in = '0;
    logic [9:0] pc_in = '0;
    logic [11:0] k_in = '0;
    logic [9:0] z_in = '0;
    logic [9:0] ret_in = '0;
    logic [7:0] sreg_in = '0;
    logic [2:0] bit_sel = '0;
    logic       skip_hit = 1'b0;
    logic       next_long = 1'b0;
    logic       out_valid;
    logic [9:0] pc_next;
    logic       taken;
    logic [2:0] cycles;
    logic       set_ie;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    exp_t last_e;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bpu_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_in(op_in), .pc_in(pc_in),
        .k_in(k_in), .z_in(z_in), .ret_in(ret_in), .sreg_in(sreg_in),
        .bit_sel(bit_sel), .skip_hit(skip_hit), .next_long(next_long),
        .out_valid(out_valid), .pc_next(pc_next), .taken(taken),
        .cycles(cycles), .set_ie(set_ie)
    );

    function automatic exp_t model(logic [3:0] op, logic [9:0] pc, logic [11:0] k,
                                   logic [9:0] z, logic [9:0] ret, logic [7:0] sr,
                                   logic [2:0] bs, logic hit, logic lng);
        exp_t e;
        logic b;
        e.si = 1'b0; e.tk = 1'b1; e.tag = "";
        case (op)
            4'd0: begin e.pc = pc + k[9:0] + 10'd1; e.cy = 3'd2; end
            4'd2: begin e.pc = pc + k[9:0] + 10'd1; e.cy = 3'd3; end
            4'd1: begin e.pc = z; e.cy = 3'd2; end
            4'd3: begin e.pc = z; e.cy = 3'd3; end
            4'd4: begin e.pc = ret; e.cy = 3'd4; end
            4'd5: begin e.pc = ret; e.cy = 3'd4; e.si = 1'b1; end
            4'd6, 4'd7: begin
                b = (bs == 3'd4) ? (sr[2] ^ sr[3]) : sr[bs];
                e.tk = (op == 4'd6) ? b : !b;
                e.pc = e.tk ? pc + {{3{k[6]}}, k[6:0]} + 10'd1 : pc + 10'd1;
                e.cy = e.tk ? 3'd2 : 3'd1;
            end
            4'd8: begin
                e.tk = hit;
                e.pc = !hit ? pc + 10'd1 : (lng ? pc + 10'd3 : pc + 10'd2);
                e.cy = !hit ? 3'd1 : (lng ? 3'd3 : 3'd2);
            end
            default: begin e.pc = pc + 10'd1; e.cy = 3'd1; e.tk = 1'b0; end
        endcase
        return e;
    endfunction

    task automatic issue(input logic [3:0] op, input logic [9:0] pc, input logic [11:0] k,
                         input logic [9:0] z, input logic [9:0] ret, input logic [7:0] sr,
                         input logic [2:0] bs, input logic hit, input logic lng,
                         input string tag);
        exp_t e;
        @(negedge clk);
        op_in = op; pc_in = pc; k_in = k; z_in = z; ret_in = ret;
        sreg_in = sr; bit_sel = bs; skip_hit = hit; next_long = lng;
        in_valid = 1'b1;
        e = model(op, pc, k, z, ret, sr, bs, hit, lng);
        e.tag = tag;
        q.push_back(e);
        last_e = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_in = 4'd0; pc_in = 10'h155; z_in = 10'h2AA; ret_in = 10'h0F0;
        end
    endtask

    // monitor: pop and compare one expected item per valid result
    always @(posedge clk) begin
        #1;
        if (!rst && out_valid) begin
            exp_t e;
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected result pc=%h act valid=1 exp valid=0", pc_next);
            end else begin
                e = q.pop_front();
                if (pc_next !== e.pc || taken !== e.tk || cycles !== e.cy || set_ie !== e.si) begin
                    n_bad++;
                    $display("FAIL %s act pc=%h tk=%b cy=%0d ie=%b exp pc=%h tk=%b cy=%0d ie=%b",
                             e.tag, pc_next, taken, cycles, set_ie, e.pc, e.tk, e.cy, e.si);
                end
            end
        end
    end

    task automatic check_hold(input string tag);
        n_chk++;
        if (out_valid !== 1'b0 || pc_next !== last_e.pc || cycles !== last_e.cy) begin
            n_bad++;
            $display("FAIL %s hold act v=%b pc=%h cy=%0d exp v=0 pc=%h cy=%0d",
                     tag, out_valid, pc_next, cycles, last_e.pc, last_e.cy);
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, during and just after reset
        n_chk++;
        if ({out_valid, pc_next, taken, cycles, set_ie} !== '0) begin
            n_bad++;
            $display("FAIL R1 act %b exp 0", {out_valid, pc_next, taken, cycles, set_ie});
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if ({out_valid, pc_next, taken, cycles, set_ie} !== '0) begin
            n_bad++;
            $display("FAIL R1 post-release act %b exp 0", {out_valid, pc_next, taken, cycles, set_ie});
        end

        // R3 relative jump / call
        issue(4'd0, 10'd100, 12'd20,    '0, '0, '0, '0, 0, 0, "R3 rjmp fwd");
        issue(4'd0, 10'd100, 12'hFFF,   '0, '0, '0, '0, 0, 0, "R3 rjmp -1");
        issue(4'd2, 10'd5,   12'h800,   '0, '0, '0, '0, 0, 0, "R3 rcall -2048");
        issue(4'd2, 10'd300, 12'h7FF,   '0, '0, '0, '0, 0, 0, "R3 rcall +2047");
        // R10 wrap
        issue(4'd0, 10'd1023, 12'd0,    '0, '0, '0, '0, 0, 0, "R10 wrap top");
        issue(4'd6, 10'd10,  12'h040,   '0, '0, 8'h01, 3'd0, 0, 0, "R10 branch -64 wrap low");
        // R4 indirect
        issue(4'd1, 10'd7, '0, 10'h3FF, '0, '0, '0, 0, 0, "R4 ijmp");
        issue(4'd3, 10'd7, '0, 10'h123, '0, '0, '0, 0, 0, "R4 icall");
        // R5 returns
        issue(4'd4, 10'd50, '0, '0, 10'h2C4, '0, '0, 0, 0, "R5 ret");
        issue(4'd5, 10'd50, '0, '0, 10'h011, '0, '0, 0, 0, "R5 reti");
        // R2 hold during idle
        idle(3);
        check_hold("R2");
        // R6 every bit, both polarities, both outcomes; R7 on bit 4
        for (int b = 0; b < 8; b++) begin
            issue(4'd6, 10'd200, 12'h03F, '0, '0, 8'(1 << b),    3'(b), 0, 0, (b == 4) ? "R7 set" : "R6 set");
            issue(4'd7, 10'd200, 12'h03F, '0, '0, 8'(1 << b),    3'(b), 0, 0, (b == 4) ? "R7 clr" : "R6 clr");
            issue(4'd6, 10'd200, 12'h07E, '0, '0, ~8'(1 << b),   3'(b), 0, 0, (b == 4) ? "R7 set inv" : "R6 set inv");
            issue(4'd7, 10'd200, 12'h07E, '0, '0, ~8'(1 << b),   3'(b), 0, 0, (b == 4) ? "R7 clr inv" : "R6 clr inv");
        end
        // R7 signed with N xor V = 1 and stored S = 0
        issue(4'd6, 10'd40, 12'h005, '0, '0, 8'h04, 3'd4, 0, 0, "R7 N^V=1");
        issue(4'd7, 10'd40, 12'h005, '0, '0, 8'h08, 3'd4, 0, 0, "R7 clr N^V=1");
        // R8 skips
        issue(4'd8, 10'd60, '0, '0, '0, '0, '0, 0, 1, "R8 miss");
        issue(4'd8, 10'd60, '0, '0, '0, '0, '0, 1, 0, "R8 hit short");
        issue(4'd8, 10'd60, '0, '0, '0, '0, '0, 1, 1, "R8 hit long");
        issue(4'd8, 10'd1022, '0, '0, '0, '0, '0, 1, 1, "R10 skip wrap");
        // R9 unused codes
        issue(4'd9,  10'd77, 12'h7FF, 10'h3FF, 10'h3FF, 8'hFF, 3'd7, 1, 1, "R9 op9");
        issue(4'd15, 10'd1023, 12'h7FF, 10'h3FF, 10'h3FF, 8'hFF, 3'd7, 1, 1, "R9 op15");
        idle(2);
        check_hold("R2 end");
        idle(2);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 act pending=%0d exp 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule